// File: doc/BRIEF.md
# Iterative TEA Block Encryptor

This block enciphers one 64-bit block under a 128-bit key with the Tiny Encryption Algorithm. The block is carried as two 32-bit halves, `y` and `z`. One shared mixing function is applied to one half per clock. Even steps update `y` and odd steps update `z`. A 32-bit running sum and a down-counting step counter sequence the 64 half-round steps of a full encryption.

A client presents the plaintext halves and the key and raises `start_i` for one cycle while the core is idle. The core captures all inputs on that edge and raises `busy_o`. After the last step it lowers `busy_o` and pulses `done_o`. The ciphertext then stays on `y_o`/`z_o` until the next accepted start.

Top module: `tea_enc_core`

## Requirements
- R1: While `rst_n` is low, and in the first idle cycle after it is released, `busy_o` and `done_o` are low and `y_o` and `z_o` read zero. Asserting `rst_n` low during a run aborts the run at once.
- R2: A `start_i` seen high at a rising edge while `busy_o` is low is accepted. On that edge `y_i`, `z_i` and `key_i` are captured, the step counter is loaded with 2*ROUNDS and the sum is cleared. `busy_o` is high from the following cycle.
- R3: `start_i` is ignored while `busy_o` is high. It does not restart the run or change its timing.
- R4: A run takes exactly 2*ROUNDS busy cycles. On the 2*ROUNDS-th edge after the accepting edge, `busy_o` falls and `done_o` rises. `done_o` stays high for exactly one cycle.
- R5: The step kind is chosen by the counter's low bit: even means a `y` step and odd means a `z` step. A `y` step first advances the sum by DELTA (0x9E3779B9). It then adds ((z<<4)+k0) ^ (z+sum) ^ ((z>>5)+k1) to `y`. All sums are taken modulo 2^32 and the shifts are logical. The key words are k0=`key_i[31:0]`, k1=`key_i[63:32]`, k2=`key_i[95:64]` and k3=`key_i[127:96]`.
- R6: A `z` step directly follows each `y` step. It uses the freshly updated `y` and the same sum, and adds ((y<<4)+k2) ^ (y+sum) ^ ((y>>5)+k3) to `z` modulo 2^32. The sum is left unchanged.
- R7: When `done_o` pulses, `y_o`/`z_o` hold the TEA ciphertext of the captured block. An all-zero key and plaintext give `y_o`=0x41EA3A0A and `z_o`=0x94BAA940.
- R8: After `done_o`, `y_o` and `z_o` keep their values until the next accepted start, whatever the other inputs do.
- R9: `y_i`, `z_i` and `key_i` are only read on the accepting edge. Changes to them during a run do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an encryption (taken only when idle) |
| y_i | input | 32 | Plaintext half y |
| z_i | input | 32 | Plaintext half z |
| key_i | input | 128 | Key, k0 in the low word up to k3 in the high word |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| y_o | output | 32 | Working / ciphertext half y |
| z_o | output | 32 | Working / ciphertext half z |

## Verification
The bench builds the core with its default parameters: 32-bit words, 32 rounds and the standard DELTA. With these settings the all-zero known answer applies, and the bench model, a loop over ROUNDS, agrees with the standard cipher. Cycle-exact probing of the first `y` and `z` steps shows that the sum advances before the first `y` step and is reused by the following `z` step. Starts and input changes injected mid-run, together with a reset mid-run, cover the ignore, latch and abort paths.

// File: rtl/tea_pkg.sv
package tea_pkg;

  // Which half the current step updates.
  typedef enum logic {
    STEP_Y = 1'b0,
    STEP_Z = 1'b1
  } tea_step_e;

  localparam int          TEA_KEY_WORDS = 4;
  localparam logic [31:0] TEA_DELTA_STD = 32'h9E3779B9;

endpackage

// File: rtl/tea_mix.sv
// Combinational round function shared by both half steps.
module tea_mix #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] v_i,
  input  logic [WORD_W-1:0] sum_i,
  input  logic [WORD_W-1:0] ka_i,
  input  logic [WORD_W-1:0] kb_i,
  output logic [WORD_W-1:0] f_o
);

  logic [WORD_W-1:0] left_term;
  logic [WORD_W-1:0] mid_term;
  logic [WORD_W-1:0] right_term;

  always_comb begin
    left_term  = (v_i << 4) + ka_i;
    mid_term   = v_i + sum_i;
    right_term = (v_i >> 5) + kb_i;
    f_o        = left_term ^ mid_term ^ right_term;
  end

endmodule

// File: rtl/tea_step_ctrl.sv
// Step counter, running sum and busy/done sequencing.
module tea_step_ctrl
  import tea_pkg::*;
#(
  parameter int                WORD_W = 32,
  parameter int                ROUNDS = 32,
  parameter logic [WORD_W-1:0] DELTA  = TEA_DELTA_STD,
  localparam int               CNT_W  = $clog2(2*ROUNDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              accept_o,
  output logic              step_en_o,
  output tea_step_e         sel_o,
  output logic [WORD_W-1:0] sum_use_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [WORD_W-1:0] sum_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam logic [CNT_W-1:0] STEPS = CNT_W'(2*ROUNDS);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sum_q, sum_d, sum_step;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              cnt_en, sum_en;
  logic              accept, last_step;
  tea_step_e         sel;

  // Next-state logic
  always_comb begin
    accept    = start_i && !busy_q;
    sel       = cnt_q[0] ? STEP_Z : STEP_Y;
    sum_step  = (sel == STEP_Y) ? (sum_q + DELTA) : sum_q;
    last_step = busy_q && (cnt_q == CNT_W'(1));

    cnt_en = accept || busy_q;
    cnt_d  = accept ? STEPS : (cnt_q - CNT_W'(1));

    sum_en = accept || (busy_q && (sel == STEP_Y));
    sum_d  = accept ? '0 : sum_step;

    if (accept) begin
      busy_d = 1'b1;
    end else if (last_step) begin
      busy_d = 1'b0;
    end else begin
      busy_d = busy_q;
    end
    done_d = last_step;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign accept_o  = accept;
  assign step_en_o = busy_q;
  assign sel_o     = sel;
  assign sum_use_o = sum_step;
  assign cnt_o     = cnt_q;
  assign sum_o     = sum_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;

endmodule

// File: rtl/tea_datapath.sv
// Half registers, captured key and the shared mixing path.
module tea_datapath
  import tea_pkg::*;
#(
  parameter int  WORD_W = 32,
  localparam int KEY_W  = TEA_KEY_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] y_i,
  input  logic [WORD_W-1:0] z_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              step_en_i,
  input  tea_step_e         sel_i,
  input  logic [WORD_W-1:0] sum_i,
  output logic [WORD_W-1:0] y_o,
  output logic [WORD_W-1:0] z_o
);

  logic [KEY_W-1:0]  key_q;
  logic [WORD_W-1:0] kw [TEA_KEY_WORDS];
  logic [WORD_W-1:0] y_q, y_d;
  logic [WORD_W-1:0] z_q, z_d;
  logic [WORD_W-1:0] mix_src, mix_ka, mix_kb, mix_f;
  logic              y_en, z_en;

  for (genvar g = 0; g < TEA_KEY_WORDS; g++) begin : g_key_word
    assign kw[g] = key_q[g*WORD_W +: WORD_W];
  end

  // Operand selection: y steps mix z with k0/k1, z steps mix y with k2/k3.
  always_comb begin
    if (sel_i == STEP_Y) begin
      mix_src = z_q;
      mix_ka  = kw[0];
      mix_kb  = kw[1];
    end else begin
      mix_src = y_q;
      mix_ka  = kw[2];
      mix_kb  = kw[3];
    end
  end

  tea_mix #(.WORD_W(WORD_W)) u_mix (
    .v_i   (mix_src),
    .sum_i (sum_i),
    .ka_i  (mix_ka),
    .kb_i  (mix_kb),
    .f_o   (mix_f)
  );

  // Next-state logic
  always_comb begin
    y_en = load_i || (step_en_i && (sel_i == STEP_Y));
    z_en = load_i || (step_en_i && (sel_i == STEP_Z));
    y_d  = load_i ? y_i : (y_q + mix_f);
    z_d  = load_i ? z_i : (z_q + mix_f);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
    end else if (load_i) begin
      key_q <= key_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else if (y_en) begin
      y_q <= y_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q <= '0;
    end else if (z_en) begin
      z_q <= z_d;
    end
  end

  assign y_o = y_q;
  assign z_o = z_q;

endmodule

// File: rtl/tea_enc_core.sv
// Iterative TEA encryptor: one half-round per clock.
module tea_enc_core
  import tea_pkg::*;
#(
  parameter int                WORD_W = 32,
  parameter int                ROUNDS = 32,
  parameter logic [WORD_W-1:0] DELTA  = TEA_DELTA_STD,
  localparam int               KEY_W  = TEA_KEY_WORDS * WORD_W,
  localparam int               CNT_W  = $clog2(2*ROUNDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] y_i,
  input  logic [WORD_W-1:0] z_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] y_o,
  output logic [WORD_W-1:0] z_o
);

  logic              accept;
  logic              step_en;
  tea_step_e         step_sel;
  logic [WORD_W-1:0] sum_use;
  logic [WORD_W-1:0] step_sum;
  logic [CNT_W-1:0]  step_cnt;

  tea_step_ctrl #(
    .WORD_W (WORD_W),
    .ROUNDS (ROUNDS),
    .DELTA  (DELTA)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .accept_o  (accept),
    .step_en_o (step_en),
    .sel_o     (step_sel),
    .sum_use_o (sum_use),
    .cnt_o     (step_cnt),
    .sum_o     (step_sum),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  tea_datapath #(.WORD_W(WORD_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept),
    .y_i       (y_i),
    .z_i       (z_i),
    .key_i     (key_i),
    .step_en_i (step_en),
    .sel_i     (step_sel),
    .sum_i     (sum_use),
    .y_o       (y_o),
    .z_o       (z_o)
  );

endmodule

// File: rtl/tea_enc_chk.sv
// Protocol and sequencing properties, bound into the core.
module tea_enc_chk #(
  parameter int                WORD_W = 32,
  parameter int                ROUNDS = 32,
  parameter logic [WORD_W-1:0] DELTA  = 32'h9E3779B9,
  localparam int               CNT_W  = $clog2(2*ROUNDS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [WORD_W-1:0] y_o,
  input logic [WORD_W-1:0] z_o,
  input logic [CNT_W-1:0]  step_cnt,
  input logic [WORD_W-1:0] step_sum
);

  localparam logic [CNT_W-1:0] STEPS = CNT_W'(2*ROUNDS);

  // R2: idle start loads the counter and clears the sum
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && step_cnt == STEPS && step_sum == '0));

  // R3: start during a run does not reload the counter
  p_ignore_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && step_cnt > CNT_W'(1)) |=>
      (busy_o && step_cnt == CNT_W'($past(step_cnt) - CNT_W'(1))));

  // R4: last step ends the run with a done pulse
  p_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && step_cnt == CNT_W'(1)) |=> (done_o && !busy_o));

  // R4: done lasts one cycle
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: a y step advances the sum by DELTA
  p_sum_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !step_cnt[0]) |=> (step_sum == $past(step_sum) + DELTA));

  // R6: a z step leaves the sum and y unchanged
  p_sum_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && step_cnt[0]) |=> ($stable(step_sum) && $stable(y_o)));

  // R8: idle without start keeps the outputs
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(y_o) && $stable(z_o)));

endmodule

bind tea_enc_core tea_enc_chk #(
  .WORD_W (WORD_W),
  .ROUNDS (ROUNDS),
  .DELTA  (DELTA)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .y_o      (y_o),
  .z_o      (z_o),
  .step_cnt (step_cnt),
  .step_sum (step_sum)
);

// File: tb/tb_tea_enc_core.sv
`timescale 1ns/1ps
module tb_tea_enc_core;

  localparam int          W      = 32;
  localparam int          ROUNDS = 32;
  localparam logic [31:0] DELTA  = 32'h9E3779B9;
  localparam int          NV     = 4;

  // Stimulus table: {y, z, key}
  localparam logic [191:0] VEC [NV] = '{
    {32'h01234567, 32'h89ABCDEF, 128'h00112233_44556677_8899AABB_CCDDEEFF},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF},
    {32'h80000000, 32'h00000001, 128'h31415926_53589793_23846264_33832795},
    {32'hDEADBEEF, 32'h0BADF00D, 128'h13579BDF_2468ACE0_FEDCBA98_76543210}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [31:0]   y_i, z_i;
  logic [127:0]  key_i;
  logic          busy_o, done_o;
  logic [31:0]   y_o, z_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tea_enc_core dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .y_i(y_i), .z_i(z_i), .key_i(key_i),
    .busy_o(busy_o), .done_o(done_o), .y_o(y_o), .z_o(z_o)
  );

  function automatic logic [31:0] mixf(logic [31:0] v, logic [31:0] s,
                                       logic [31:0] ka, logic [31:0] kb);
    return ((v << 4) + ka) ^ (v + s) ^ ((v >> 5) + kb);
  endfunction

  function automatic logic [63:0] tea_ref(logic [31:0] y, logic [31:0] z,
                                          logic [127:0] k);
    logic [31:0] s = '0;
    for (int r = 0; r < ROUNDS; r++) begin
      s = s + DELTA;
      y = y + mixf(z, s, k[31:0], k[63:32]);
      z = z + mixf(y, s, k[95:64], k[127:96]);
    end
    return {y, z};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Drive a start at a negedge; returns at the next negedge (busy visible).
  task automatic launch(input logic [31:0] y, input logic [31:0] z,
                        input logic [127:0] k);
    @(negedge clk);
    y_i = y; z_i = z; key_i = k; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done_o && n < 1000);
  endtask

  task automatic full_run(input logic [31:0] y, input logic [31:0] z,
                          input logic [127:0] k, input string tag);
    int n;
    logic [63:0] exp;
    exp = tea_ref(y, z, k);
    launch(y, z, k);
    chk(busy_o === 1'b1, "R2 busy after start", {63'd0, busy_o}, 64'd1);
    wait_done(n);
    chk(n == 2*ROUNDS, "R4 latency", 64'(n), 64'(2*ROUNDS));
    chk(busy_o === 1'b0, "R4 busy low at done", {63'd0, busy_o}, 64'd0);
    chk({y_o, z_o} === exp, tag, {y_o, z_o}, exp);
    @(negedge clk);
    chk(done_o === 1'b0, "R4 done single cycle", {63'd0, done_o}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R4 watchdog expired act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic [31:0]  y1, z1, y2;
    logic [63:0]  exp_a;
    logic [127:0] ka;

    rst_n = 1'b0; start_i = 1'b0; y_i = '0; z_i = '0; key_i = '0;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o} === 2'b00, "R1 flags in reset", {62'd0, busy_o, done_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({y_o, z_o} === 64'd0, "R1 outputs after reset", {y_o, z_o}, 64'd0);
    chk({busy_o, done_o} === 2'b00, "R1 idle after reset", {62'd0, busy_o, done_o}, 64'd0);

    // R7: table of vectors against the bench model
    for (int i = 0; i < NV; i++) begin
      full_run(VEC[i][191:160], VEC[i][159:128], VEC[i][127:0], "R7 vector vs model");
    end

    // R7: all-zero known answer
    full_run(32'd0, 32'd0, 128'd0, "R7 model zero");
    chk({y_o, z_o} === 64'h41EA3A0A_94BAA940, "R7 zero known answer",
        {y_o, z_o}, 64'h41EA3A0A_94BAA940);

    // R5/R6: first y and z steps, cycle by cycle
    ka = VEC[0][127:0];
    launch(VEC[0][191:160], VEC[0][159:128], ka);
    chk(y_o === VEC[0][191:160], "R2 y captured, no step yet", {32'd0, y_o}, {32'd0, VEC[0][191:160]});
    y1 = VEC[0][191:160] + mixf(VEC[0][159:128], DELTA, ka[31:0], ka[63:32]);
    @(negedge clk);
    chk(y_o === y1, "R5 first y step uses DELTA", {32'd0, y_o}, {32'd0, y1});
    chk(z_o === VEC[0][159:128], "R5 z untouched on y step", {32'd0, z_o}, {32'd0, VEC[0][159:128]});
    z1 = VEC[0][159:128] + mixf(y1, DELTA, ka[95:64], ka[127:96]);
    @(negedge clk);
    chk(z_o === z1, "R6 z step with new y, same sum", {32'd0, z_o}, {32'd0, z1});
    chk(y_o === y1, "R6 y untouched on z step", {32'd0, y_o}, {32'd0, y1});
    y2 = y1 + mixf(z1, DELTA + DELTA, ka[31:0], ka[63:32]);
    @(negedge clk);
    chk(y_o === y2, "R5 second y step uses 2*DELTA", {32'd0, y_o}, {32'd0, y2});
    wait_done(n);
    chk(n == 2*ROUNDS - 3, "R4 latency probed run", 64'(n), 64'(2*ROUNDS - 3));

    // R3/R9: start and input changes mid-run
    exp_a = tea_ref(VEC[3][191:160], VEC[3][159:128], VEC[3][127:0]);
    launch(VEC[3][191:160], VEC[3][159:128], VEC[3][127:0]);
    repeat (8) @(negedge clk);
    start_i = 1'b1; y_i = 32'h55555555; z_i = 32'hAAAAAAAA; key_i = ~VEC[3][127:0];
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R3 still busy after mid-run start", {63'd0, busy_o}, 64'd1);
    wait_done(n);
    chk(n == 2*ROUNDS - 9, "R3 timing unchanged", 64'(n), 64'(2*ROUNDS - 9));
    chk({y_o, z_o} === exp_a, "R9 result ignores mid-run inputs", {y_o, z_o}, exp_a);

    // R8: outputs hold while idle with changing inputs
    repeat (6) begin
      @(negedge clk);
      y_i = ~y_i; key_i = {key_i[126:0], key_i[127]};
    end
    chk({y_o, z_o} === exp_a, "R8 ciphertext held", {y_o, z_o}, exp_a);

    // R1: reset during a run aborts it
    launch(VEC[1][191:160], VEC[1][159:128], VEC[1][127:0]);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({busy_o, done_o} === 2'b00, "R1 async abort flags", {62'd0, busy_o, done_o}, 64'd0);
    chk({y_o, z_o} === 64'd0, "R1 async abort outputs", {y_o, z_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    full_run(VEC[2][191:160], VEC[2][159:128], VEC[2][127:0], "R7 run after abort");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule